// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block drives one raw 8-bit NAND flash device and runs one complete flash operation per start request. Software first fills a small set of registers: the first command opcode, up to five address bytes, an optional second opcode and a byte count. It then writes the control word with its start bit set. The engine lowers chip enable, waits a programmable setup time and issues the command strobe. The address strobes follow. A write operation then sends the data bytes, and after that the optional confirm opcode. A read operation sends the optional opcode (for example read start) next.

After the last command cycle the engine waits a guard interval before it looks at ready/busy. It then waits for the device to become ready. A read operation next clocks the requested bytes into a local page buffer. When the operation finishes, the engine clears the start bit, raises chip enable and sets a completion flag that can drive an interrupt. The host stages write data through one byte window of the buffer and collects read data through another.

Typical operations are an ID read (one opcode, one address byte, a few data bytes), a page read (opcode, five address bytes, read-start opcode, busy wait, data), a page program (opcode, address, data, confirm, busy wait) and a block erase (opcode, three address bytes, confirm, busy wait).

Top module: `nand_op_engine`

## Requirements
- R1: Writing control word 1 (offset 0x000) with bit 31 set while the engine is idle starts an operation. Bit 31 of control word 1 and status bit 0 (offset 0x01C) read 1 while the operation runs. Both read 0 once it has finished.
- R2: Latched bytes follow a fixed order. The first opcode (control word 1 bits 7:0) goes out with the command latch. The address bytes follow with the address latch, low byte first: address register low (0x00C) bits 7:0 and 15:8, then address register high (0x010) bits 7:0, 15:8, 23:16. Write data, the second opcode and read data come after them.
- R3: Address cycles happen only when control word 1 bit 30 is set. Bits 29:27 then hold the count minus one. Field values 4 to 7 all give five address bytes. With bit 30 clear there are no address cycles.
- R4: Control word 2 (0x004) bit 8 enables a second command cycle carrying bits 7:0. It follows the address bytes, or the write data when the operation writes.
- R5: Control word 1 bit 26 selects a data read phase and bit 25 a data write phase. Read wins when both bits are set. The byte count at 0x008 is clamped to the buffer size, and a count of 0 means no data phase. Read bytes land at buffer index 0 upward and show at 0x1000+i. Write bytes come from buffer index 0 upward and are loaded at 0x2000+i.
- R6: After the last command cycle, ready/busy is ignored for timing register B (0x024) bits 7:0 cycles. The engine then waits for ready high before it reads data or finishes.
- R7: Each write or read strobe is low for timing A (0x020) bits 3:0 plus 1 cycles and high for bits 11:8 plus 1 cycles. Chip enable falls timing C (0x028) bits 27:24 plus 1 cycles before the first strobe. The timing registers reset to 0x01010A0A, 0x24121212 and 0x11000000.
- R8: Completion sets interrupt status bit 31 (0x014). Writing 1 to that bit clears it, and writing 0 has no effect. The interrupt pin equals status bit 31 AND mask bit 31 (0x018), and the mask resets to 0.
- R9: A control word 1 write while an operation runs is ignored: its value is not stored and no second operation starts.
- R10: Status bit 1 mirrors the ready/busy pin through a two-flop synchronizer.
- R11: Command latch and address latch are never high together. Write and read strobes are never low together. The data bus is not driven while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 14 | Register or buffer window byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Completion interrupt, masked |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb | input | 1 | Ready/busy, high when ready |

## Verification
The bench contains a flash device model that records every latched byte with its latch type. After a confirm opcode it pulls ready/busy low after a short delay, and it serves a known byte pattern on read strobes. Each operation's recorded sequence is compared against an expected list built from the programmed registers.

The operation shapes used are:
- an ID read with one address byte;
- a five-byte page read with a start opcode;
- a program with a confirm after the data;
- an erase with three address bytes;
- an oversized address count;
- a disabled address phase;
- a zero-length read;
- an oversized read with both direction bits set.

Together these separate the ordering, count-clamping and direction rules. On every clock the model also flags pin-rule violations and any read strobe or completion that occurs while the device is busy, which exposes a missing guard interval. Strobe low widths and the setup gap are measured at the pins.

// File: rtl/nand_op_engine.sv
module nand_op_engine #(
  parameter int BUF_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [13:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_o,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_i,
  input  logic        nand_rb
);
  localparam int BW = $clog2(BUF_BYTES);
  localparam int LW = BW + 1;
  localparam logic [13:0] A_CTL1 = 14'h000, A_CTL2 = 14'h004, A_LEN  = 14'h008,
                          A_ADLO = 14'h00C, A_ADHI = 14'h010, A_IRQ  = 14'h014,
                          A_MASK = 14'h018, A_STAT = 14'h01C, A_TIMA = 14'h020,
                          A_TIMB = 14'h024, A_TIMC = 14'h028;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_TWB, S_WAIT, S_RDATA
  } st_t;

  st_t         state, nxt;
  logic [31:0] ctl1, tim_a, tim_b, tim_c;
  logic [8:0]  ctl2;
  logic [15:0] dlen, adr_lo;
  logic [23:0] adr_hi;
  logic        irq_st, irq_msk, rb_m, rb_s, ph, adv, inc, fin, start;
  logic [7:0]  cnt;
  logic [LW-1:0] idx, nbytes;
  logic [2:0]  naddr;
  logic        rd_ph, wr_ph, c2_en, byte_end, drive_st;
  logic [7:0]  pbuf [BUF_BYTES];
  logic [39:0] adr_all;
  st_t         after_addr, after_wdata;

  assign start   = reg_we && reg_addr == A_CTL1 && reg_wdata[31] && state == S_IDLE;
  assign naddr   = !ctl1[30] ? 3'd0 : (ctl1[29:27] >= 3'd4) ? 3'd5 : ctl1[29:27] + 3'd1;
  assign nbytes  = (dlen > 16'(BUF_BYTES)) ? LW'(BUF_BYTES) : dlen[LW-1:0];
  assign rd_ph   = ctl1[26] && nbytes != '0;
  assign wr_ph   = ctl1[25] && !ctl1[26] && nbytes != '0;
  assign c2_en   = ctl2[8];
  assign adr_all = {adr_hi, adr_lo};
  assign drive_st = state inside {S_CMD1, S_ADDR, S_WDATA, S_CMD2};
  assign byte_end = (drive_st || state == S_RDATA) && ph && cnt == {4'b0, tim_a[11:8]};
  assign after_wdata = c2_en ? S_CMD2 : S_TWB;
  assign after_addr  = wr_ph ? S_WDATA : after_wdata;

  always_comb begin
    nxt = state;
    adv = 1'b0;
    inc = 1'b0;
    case (state)
      S_IDLE:  if (start) begin nxt = S_SETUP; adv = 1'b1; end
      S_SETUP: if (cnt == {4'b0, tim_c[27:24]}) begin nxt = S_CMD1; adv = 1'b1; end
      S_CMD1:  if (byte_end) begin adv = 1'b1; nxt = (naddr != 3'd0) ? S_ADDR : after_addr; end
      S_ADDR:  if (byte_end) begin
                 adv = 1'b1;
                 if (idx == {{(LW-3){1'b0}}, naddr - 3'd1}) nxt = after_addr; else inc = 1'b1;
               end
      S_WDATA: if (byte_end) begin
                 adv = 1'b1;
                 if (idx == nbytes - LW'(1)) nxt = after_wdata; else inc = 1'b1;
               end
      S_CMD2:  if (byte_end) begin adv = 1'b1; nxt = S_TWB; end
      S_TWB:   if (cnt == tim_b[7:0]) begin adv = 1'b1; nxt = S_WAIT; end
      S_WAIT:  if (rb_s) begin adv = 1'b1; nxt = rd_ph ? S_RDATA : S_IDLE; end
      S_RDATA: if (byte_end) begin
                 adv = 1'b1;
                 if (idx == nbytes - LW'(1)) nxt = S_IDLE; else inc = 1'b1;
               end
      default: begin adv = 1'b1; nxt = S_IDLE; end
    endcase
  end

  assign fin = adv && nxt == S_IDLE && state != S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ph    <= 1'b0;
      cnt   <= '0;
      idx   <= '0;
    end else if (adv) begin
      state <= nxt;
      ph    <= 1'b0;
      cnt   <= '0;
      idx   <= inc ? idx + LW'(1) : '0;
    end else if (state != S_IDLE && state != S_WAIT) begin
      if ((drive_st || state == S_RDATA) && !ph && cnt == {4'b0, tim_a[3:0]}) begin
        ph  <= 1'b1;
        cnt <= '0;
      end else begin
        cnt <= cnt + 8'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1 <= '0;  ctl2 <= '0;  dlen <= '0;  adr_lo <= '0;  adr_hi <= '0;
      tim_a <= 32'h0101_0A0A;  tim_b <= 32'h2412_1212;  tim_c <= 32'h1100_0000;
      irq_st <= 1'b0;  irq_msk <= 1'b0;  rb_m <= 1'b0;  rb_s <= 1'b0;
    end else begin
      rb_m <= nand_rb;
      rb_s <= rb_m;
      if (reg_we) begin
        case (reg_addr)
          A_CTL1: if (state == S_IDLE) ctl1 <= reg_wdata;
          A_CTL2: ctl2 <= reg_wdata[8:0];
          A_LEN:  dlen <= reg_wdata[15:0];
          A_ADLO: adr_lo <= reg_wdata[15:0];
          A_ADHI: adr_hi <= reg_wdata[23:0];
          A_IRQ:  if (reg_wdata[31]) irq_st <= 1'b0;
          A_MASK: irq_msk <= reg_wdata[31];
          A_TIMA: tim_a <= reg_wdata;
          A_TIMB: tim_b <= reg_wdata;
          A_TIMC: tim_c <= reg_wdata;
          default: ;
        endcase
      end
      if (fin) begin
        irq_st   <= 1'b1;
        ctl1[31] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (reg_we && reg_addr[13:12] == 2'b10)
      pbuf[reg_addr[BW-1:0]] <= reg_wdata[7:0];
    if (state == S_RDATA && !ph && cnt == {4'b0, tim_a[3:0]})
      pbuf[idx[BW-1:0]] <= nand_dq_i;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[13:12] == 2'b01) begin
      reg_rdata = {24'b0, pbuf[reg_addr[BW-1:0]]};
    end else if (reg_addr[13:12] == 2'b00) begin
      case (reg_addr)
        A_CTL1: reg_rdata = ctl1;
        A_CTL2: reg_rdata = {23'b0, ctl2};
        A_LEN:  reg_rdata = {16'b0, dlen};
        A_ADLO: reg_rdata = {16'b0, adr_lo};
        A_ADHI: reg_rdata = {8'b0, adr_hi};
        A_IRQ:  reg_rdata = {irq_st, 31'b0};
        A_MASK: reg_rdata = {irq_msk, 31'b0};
        A_STAT: reg_rdata = {30'b0, rb_s, state != S_IDLE};
        A_TIMA: reg_rdata = tim_a;
        A_TIMB: reg_rdata = tim_b;
        A_TIMC: reg_rdata = tim_c;
        default: reg_rdata = '0;
      endcase
    end
  end

  always_comb begin
    case (state)
      S_CMD1:  nand_dq_o = ctl1[7:0];
      S_ADDR:  nand_dq_o = adr_all[{idx[2:0], 3'b000} +: 8];
      S_WDATA: nand_dq_o = pbuf[idx[BW-1:0]];
      S_CMD2:  nand_dq_o = ctl2[7:0];
      default: nand_dq_o = 8'h00;
    endcase
  end

  assign irq        = irq_st & irq_msk;
  assign nand_ce_n  = state == S_IDLE;
  assign nand_cle   = state == S_CMD1 || state == S_CMD2;
  assign nand_ale   = state == S_ADDR;
  assign nand_dq_oe = drive_st;
  assign nand_we_n  = !(drive_st && !ph);
  assign nand_re_n  = !(state == S_RDATA && !ph);

  logic [7:0] since_cmd;
  logic       we_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_cmd <= '0;
      we_q      <= 1'b1;
    end else begin
      we_q <= nand_we_n;
      if (nand_cle && nand_we_n && !we_q) since_cmd <= '0;
      else if (since_cmd != 8'hFF) since_cmd <= since_cmd + 8'd1;
    end
  end

  assert_twb_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> since_cmd >= tim_b[7:0]);
  assert_latch_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  assert_bus_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);
  assert_done_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_ce_n) |-> irq_st);
  assert_busy_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_ce_n && reg_we && reg_addr == A_CTL1) |=> $stable(ctl1[30:0]));
  assert_addr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nand_ale |-> idx < LW'(5));
endmodule

// File: tb/sim_nand_op_engine.sv
module sim_nand_op_engine;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, reg_we = 1'b0;
  logic [13:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, ce_n, cle, ale, we_n, re_n, dq_oe;
  logic [7:0]  dq_o, dq_i;
  logic        rb_drv = 1'b1, rb_force = 1'b0;
  wire         nand_rb = rb_drv & ~rb_force;

  nand_op_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n),
    .nand_re_n(re_n), .nand_dq_o(dq_o), .nand_dq_oe(dq_oe),
    .nand_dq_i(dq_i), .nand_rb(nand_rb)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [9:0] lat_q[$];
  logic [9:0] exp_q[$];
  int rd_cnt = 0, rd_idx = 0, start_cnt = 0, busy_cnt = 0;
  int viol = 0, proto = 0, wlo_bad = 0, lo_run = 0, exp_lo = 11;
  int su_run = 0, su_meas = -1;
  bit seen_we = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;

  function automatic logic [7:0] pat(input int i);
    return 8'h3C ^ 8'(i * 7);
  endfunction
  assign dq_i = pat(rd_idx);

  // behavioural flash device: latch log, busy after confirm, read pattern, pin rules
  always @(negedge clk) if (rst_n) begin
    if (cle && ale) proto++;
    if (!we_n && !re_n) proto++;
    if (!re_n && dq_oe) proto++;
    if (ce_n) begin su_run = 0; seen_we = 0; end
    else if (!seen_we) begin
      if (!we_n) begin seen_we = 1; su_meas = su_run; end else su_run++;
    end
    if (!prev_we && we_n) begin
      lat_q.push_back({cle, ale, dq_o});
      if (lo_run != exp_lo) wlo_bad++;
      if (cle) begin
        rd_idx = 0;
        if (dq_o == 8'h30 || dq_o == 8'h10 || dq_o == 8'hD0) start_cnt = 3;
      end
    end
    if (!we_n) lo_run = prev_we ? 1 : lo_run + 1;
    if (prev_re && !re_n && (!rb_drv || start_cnt > 0)) viol++;
    if (!prev_re && re_n) begin rd_idx++; rd_cnt++; end
    if (ce_n && (!rb_drv || start_cnt > 0)) viol++;
    if (start_cnt > 0) begin
      start_cnt--;
      if (start_cnt == 0) begin rb_drv = 1'b0; busy_cnt = 20; end
    end else if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0) rb_drv = 1'b1;
    end
    prev_we = we_n;
    prev_re = re_n;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] mk(input logic [7:0] c, input int na, input bit r, input bit w);
    logic [31:0] v;
    v = 32'h8000_0000 | {24'b0, c} | (32'(r) << 26) | (32'(w) << 25);
    if (na > 0) v = v | 32'h4000_0000 | (32'(na - 1) << 27);
    return v;
  endfunction

  task automatic start_op(input logic [31:0] c1);
    lat_q.delete();
    rd_cnt = 0;
    wr(14'h000, c1);
  endtask

  task automatic wait_op();
    logic [31:0] d;
    do rd(14'h01C, d); while (d[0]);
  endtask

  task automatic cmp_seq(input string req);
    int bad;
    bad = (lat_q.size() != exp_q.size()) ? 1 : 0;
    if (!bad) foreach (exp_q[i]) if (lat_q[i] != exp_q[i]) bad++;
    chk(bad == 0, req, 32'(lat_q.size()), 32'(exp_q.size()));
    if (bad != 0) foreach (lat_q[i]) $display("  got %h", lat_q[i]);
  endtask

  function automatic void pc(input logic [7:0] b); exp_q.push_back({2'b10, b}); endfunction
  function automatic void pa(input logic [7:0] b); exp_q.push_back({2'b01, b}); endfunction
  function automatic void pd(input logic [7:0] b); exp_q.push_back({2'b00, b}); endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=idle");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(14'h020, d); chk(d == 32'h0101_0A0A, "R7 timing A reset", d, 32'h0101_0A0A);
    rd(14'h024, d); chk(d == 32'h2412_1212, "R7 timing B reset", d, 32'h2412_1212);
    rd(14'h028, d); chk(d == 32'h1100_0000, "R7 timing C reset", d, 32'h1100_0000);
    rd(14'h01C, d); chk(d == 32'h2, "R1 R10 status reset", d, 32'h2);
    rd(14'h014, d); chk(d == 0 && !irq, "R8 irq reset", d, 0);
    chk(ce_n && we_n && re_n && !dq_oe, "R11 pins idle", {ce_n, we_n, re_n, dq_oe}, 4'b1110);

    // ID read with reset timing
    wr(14'h00C, 0); wr(14'h004, 0); wr(14'h008, 5);
    start_op(mk(8'h90, 1, 1, 0));
    rd(14'h000, d); chk(d[31] == 1'b1, "R1 start bit while running", d, 32'h8000_0000);
    rd(14'h01C, d); chk(d[0] == 1'b1, "R1 status running", d, 1);
    wait_op();
    exp_q.delete(); pc(8'h90); pa(8'h00);
    cmp_seq("R2 ID read sequence");
    chk(rd_cnt == 5, "R5 ID read byte count", rd_cnt, 5);
    bad = 0;
    for (int i = 0; i < 5; i++) begin rd(14'h1000 + 14'(i), d); if (d[7:0] != pat(i)) bad++; end
    chk(bad == 0, "R5 ID data in read window", bad, 0);
    rd(14'h000, d); chk(d[31] == 1'b0, "R1 start bit cleared", d, 0);
    chk(wlo_bad == 0, "R7 write strobe low width", wlo_bad, 0);
    chk(su_meas == 2, "R7 setup before first strobe", su_meas, 2);
    rd(14'h014, d); chk(d[31] && !irq, "R8 flag set, pin masked", {d[31], irq}, 2'b10);

    // faster timing
    wr(14'h020, 32'h0000_0201); exp_lo = 2; wlo_bad = 0;

    // page read
    wr(14'h00C, 32'h0004); wr(14'h010, 32'h012345); wr(14'h004, 32'h130); wr(14'h008, 16);
    start_op(mk(8'h00, 5, 1, 0)); wait_op();
    exp_q.delete(); pc(8'h00); pa(8'h04); pa(8'h00); pa(8'h45); pa(8'h23); pa(8'h01); pc(8'h30);
    cmp_seq("R2 R4 page read sequence");
    chk(viol == 0, "R6 no read while busy", viol, 0);
    chk(rd_cnt == 16, "R5 page read count", rd_cnt, 16);
    bad = 0;
    for (int i = 0; i < 16; i++) begin rd(14'h1000 + 14'(i), d); if (d[7:0] != pat(i)) bad++; end
    chk(bad == 0, "R5 page data", bad, 0);

    // program
    for (int i = 0; i < 8; i++) wr(14'h2000 + 14'(i), 32'(8'hF0 + 8'(i)));
    wr(14'h00C, 0); wr(14'h010, 32'h000002); wr(14'h004, 32'h110); wr(14'h008, 8);
    start_op(mk(8'h80, 5, 0, 1)); wait_op();
    exp_q.delete(); pc(8'h80); pa(8'h00); pa(8'h00); pa(8'h02); pa(8'h00); pa(8'h00);
    for (int i = 0; i < 8; i++) pd(8'hF0 + 8'(i));
    pc(8'h10);
    cmp_seq("R2 R4 program sequence");
    chk(viol == 0 && rd_cnt == 0, "R6 program busy wait", viol + rd_cnt, 0);
    chk(wlo_bad == 0, "R7 fast strobe width", wlo_bad, 0);

    // erase with start write while busy
    wr(14'h00C, 32'h1234); wr(14'h010, 32'h56); wr(14'h004, 32'h1D0); wr(14'h008, 0);
    start_op(mk(8'h60, 3, 0, 0));
    repeat (10) @(negedge clk);
    wr(14'h000, mk(8'h70, 1, 1, 0));
    wait_op();
    exp_q.delete(); pc(8'h60); pa(8'h34); pa(8'h12); pa(8'h56); pc(8'hD0);
    cmp_seq("R2 R4 erase sequence");
    rd(14'h000, d); chk(d == (mk(8'h60, 3, 0, 0) & 32'h7FFF_FFFF), "R9 busy write dropped", d, mk(8'h60, 3, 0, 0) & 32'h7FFF_FFFF);
    repeat (40) @(negedge clk);
    rd(14'h01C, d); chk(d[0] == 0 && lat_q.size() == 5, "R9 no second operation", 32'(lat_q.size()), 5);

    // address count clamp
    wr(14'h00C, 32'hBBAA); wr(14'h010, 32'hEEDDCC); wr(14'h004, 0);
    start_op(mk(8'h00, 8, 0, 0)); wait_op();
    exp_q.delete(); pc(8'h00); pa(8'hAA); pa(8'hBB); pa(8'hCC); pa(8'hDD); pa(8'hEE);
    cmp_seq("R3 count field 7 gives five bytes");

    // address phase disabled
    start_op(32'h8000_0000 | (32'd2 << 27) | 32'hFF); wait_op();
    exp_q.delete(); pc(8'hFF);
    cmp_seq("R3 address phase disabled");

    // zero-length read
    wr(14'h00C, 32'h0000); wr(14'h004, 32'h130); wr(14'h008, 0);
    start_op(mk(8'h00, 2, 1, 0)); wait_op();
    exp_q.delete(); pc(8'h00); pa(8'hAA); pa(8'hBB); pc(8'h30);
    exp_q[1] = {2'b01, 8'h00}; exp_q[2] = {2'b01, 8'h00};
    cmp_seq("R4 R5 zero-length read sequence");
    chk(rd_cnt == 0 && viol == 0, "R5 zero length no strobes", rd_cnt, 0);

    // both directions, oversized length
    wr(14'h008, 100);
    start_op(mk(8'h00, 2, 1, 1)); wait_op();
    cmp_seq("R5 read wins, no write data");
    chk(rd_cnt == 64, "R5 length clamped to buffer", rd_cnt, 64);

    // interrupt mask and clear
    wr(14'h018, 32'h8000_0000); @(negedge clk);
    chk(irq == 1'b1, "R8 irq pin with mask", irq, 1);
    wr(14'h014, 0); rd(14'h014, d);
    chk(d[31] && irq, "R8 write 0 keeps flag", d, 32'h8000_0000);
    wr(14'h014, 32'h8000_0000); rd(14'h014, d);
    chk(!d[31] && !irq, "R8 write 1 clears flag", {d[31], irq}, 0);

    // ready/busy mirror
    rb_force = 1'b1; repeat (4) @(negedge clk);
    rd(14'h01C, d); chk(d[1] == 1'b0, "R10 status mirrors busy", d, 0);
    rb_force = 1'b0; repeat (4) @(negedge clk);
    rd(14'h01C, d); chk(d[1] == 1'b1, "R10 status mirrors ready", d, 2);

    chk(proto == 0, "R11 pin rules", proto, 0);
    chk(viol == 0, "R6 no early completion", viol, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule